// File: doc/BRIEF.md
# Byte-Granular Erase/Write Memory Update Controller

This block sequences changes to a 256 x 8 non-volatile memory model in which a cell can only be driven to one by an erase step and only to zero by a write step. Each byte update runs an optional erase phase, which sets the whole byte to all ones, and then an optional write phase, which ANDs the byte with the new data. The controller looks at the stored byte and the requested value. It runs a phase only when at least one bit needs the transition that phase provides, so an update that changes nothing costs no phase time.

The lowest 32 bytes can each be locked by a one-time protection bit. Each protection bit has the same index as the byte it guards. A lock request sets the bit using one write phase. Once set, the bit stays set until the next reset, and any update to that byte is refused. A combinational read port returns any byte and its protection bit. A busy level shows that a phase is running, and a one-cycle done pulse, qualified by a rejected flag, marks the end of every accepted request.

Top module: `eeprom_update_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF on the read port, every protection bit reads 0, busy is 0 and done is 0.
- R2: After an accepted update, the byte reads exactly the new data. That value is the AND of the new data with either the erased value 0xFF or, if no erase ran, the old content.
- R3: An erase phase runs only when (~old & new) is non-zero, and it lasts PHASE_CYCLES clock cycles.
- R4: A write phase runs only when (base & ~new) is non-zero, and it lasts PHASE_CYCLES cycles. Here base is 0xFF if an erase ran, or the old byte if it did not.
- R5: An update that needs neither phase raises done in the cycle after the request edge and never raises busy.
- R6: Busy is 1 exactly while a phase runs. An update or lock request presented while busy is 1 is ignored.
- R7: Done is a single-cycle pulse. It is high in the cycle after the last phase edge, so the request edge is followed by 1 + k*PHASE_CYCLES edges, where k is the number of phases run.
- R8: An update to a byte at address 0..31 whose protection bit is 1 raises done and rejected in the cycle after the request, and leaves the byte unchanged.
- R9: A lock request to address 0..31 sets that byte's protection bit after one write phase. If the bit is already set, done follows at once with rejected 0. A lock request to address 32 or above is refused at once with rejected 1. No request ever clears a protection bit. An update request takes priority over a lock request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | Update strobe for byte `addr` with value `wdata` |
| lock_req | input | 1 | Lock strobe for the protection bit of byte `addr` |
| addr | input | 8 | Target byte address of a request |
| wdata | input | 8 | New data for an update |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Byte at `rd_addr` |
| rd_locked | output | 1 | Protection bit of `rd_addr` (0 above 31) |
| busy | output | 1 | A phase is running |
| done | output | 1 | One-cycle end-of-request pulse |
| rejected | output | 1 | Qualifies `done`: request refused |

## Verification
The bench measures the latency of every request in edges. This separates updates with no phase, erase only, write only, and erase plus write. A design that erased unconditionally or skipped the write after an erase shows up as a wrong latency or a wrong read value. Locked bytes 0..31 are hit with updates and relocks, and address 32 with a lock request, which catches off-by-one range decoding and protection bits that can be cleared. A second request issued mid-phase must leave its target byte at 0xFF, which exposes a controller that accepts requests while busy.

// File: rtl/eeprom_update_pkg.sv
package eeprom_update_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2
  } upd_state_e;

  typedef enum logic {
    OP_DATA = 1'b0,
    OP_LOCK = 1'b1
  } upd_op_e;
endpackage

// File: rtl/eeprom_phase_plan.sv
module eeprom_phase_plan #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] new_val,
  output logic              need_erase,
  output logic              need_write
);
  logic [DATA_W-1:0] base_val;

  always_comb begin
    need_erase = |(~cur_val & new_val);
    base_val   = need_erase ? {DATA_W{1'b1}} : cur_val;
    need_write = |(base_val & ~new_val);
  end
endmodule

// File: rtl/eeprom_lock_store.sv
module eeprom_lock_store #(
  parameter int LOCK_N = 32,
  localparam int IDX_W = $clog2(LOCK_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             bit_a,
  output logic             bit_b,
  output logic [LOCK_N-1:0] lock_vec
);
  logic [LOCK_N-1:0] lock_q;

  for (genvar g = 0; g < LOCK_N; g++) begin : g_bit
    logic lock_d;
    always_comb begin
      lock_d = lock_q[g];
      if (set_en && (set_idx == IDX_W'(g))) lock_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[g] <= 1'b0;
      else        lock_q[g] <= lock_d;
    end
  end

  assign bit_a    = lock_q[idx_a];
  assign bit_b    = lock_q[idx_b];
  assign lock_vec = lock_q;
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic              write_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wmask,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = mem_q[waddr];
    if (erase_en)      word_d = {DATA_W{1'b1}};
    else if (write_en) word_d = mem_q[waddr] & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= {DATA_W{1'b1}};
    end else if (erase_en || write_en) begin
      mem_q[waddr] <= word_d;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/eeprom_phase_timer.sv
module eeprom_phase_timer #(
  parameter int PHASE_CYCLES = 12,
  localparam int CNT_W = $clog2(PHASE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = run && (cnt_q == CNT_W'(PHASE_CYCLES - 1));
endmodule

// File: rtl/eeprom_update_ctrl.sv
module eeprom_update_ctrl
  import eeprom_update_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int LOCK_N       = 32,
  parameter int PHASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_req,
  input  logic              lock_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_locked,
  output logic              busy,
  output logic              done,
  output logic              rejected
);
  localparam int IDX_W = $clog2(LOCK_N);

  upd_state_e        state_q, state_d;
  upd_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              need_w_q, need_w_d;
  logic              done_q, done_d;
  logic              rej_q, rej_d;

  logic              tmr_start, tmr_last, tmr_run;
  logic              erase_en, write_en, lock_set;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] cur_byte;
  logic              plan_erase, plan_write;
  logic              req_in_range, rd_in_range;
  logic              req_locked, rd_lock_raw;
  logic [LOCK_N-1:0] lock_vec;

  assign req_in_range = (addr < ADDR_W'(LOCK_N));
  assign rd_in_range  = (rd_addr < ADDR_W'(LOCK_N));
  assign tmr_run      = (state_q != ST_IDLE);
  assign arr_waddr    = tmr_run ? addr_q : addr;

  eeprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk, .rst_n,
    .erase_en, .write_en,
    .waddr(arr_waddr), .wmask(data_q),
    .raddr_a(addr), .raddr_b(rd_addr),
    .rdata_a(cur_byte), .rdata_b(rd_data)
  );

  eeprom_phase_plan #(.DATA_W(DATA_W)) u_plan (
    .cur_val(cur_byte), .new_val(wdata),
    .need_erase(plan_erase), .need_write(plan_write)
  );

  eeprom_lock_store #(.LOCK_N(LOCK_N)) u_lock (
    .clk, .rst_n,
    .set_en(lock_set), .set_idx(addr_q[IDX_W-1:0]),
    .idx_a(addr[IDX_W-1:0]), .idx_b(rd_addr[IDX_W-1:0]),
    .bit_a(req_locked), .bit_b(rd_lock_raw),
    .lock_vec
  );

  eeprom_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk, .rst_n, .start(tmr_start), .run(tmr_run), .last(tmr_last)
  );

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    addr_d    = addr_q;
    data_d    = data_q;
    need_w_d  = need_w_q;
    done_d    = 1'b0;
    rej_d     = 1'b0;
    tmr_start = 1'b0;
    erase_en  = 1'b0;
    write_en  = 1'b0;
    lock_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (upd_req) begin
          if (req_in_range && req_locked) begin
            done_d = 1'b1;
            rej_d  = 1'b1;
          end else if (plan_erase || plan_write) begin
            op_d      = OP_DATA;
            addr_d    = addr;
            data_d    = wdata;
            need_w_d  = plan_write;
            tmr_start = 1'b1;
            state_d   = plan_erase ? ST_ERASE : ST_WRITE;
          end else begin
            done_d = 1'b1;
          end
        end else if (lock_req) begin
          if (!req_in_range) begin
            done_d = 1'b1;
            rej_d  = 1'b1;
          end else if (req_locked) begin
            done_d = 1'b1;
          end else begin
            op_d      = OP_LOCK;
            addr_d    = addr;
            tmr_start = 1'b1;
            state_d   = ST_WRITE;
          end
        end
      end
      ST_ERASE: begin
        if (tmr_last) begin
          erase_en = 1'b1;
          if (need_w_q) begin
            tmr_start = 1'b1;
            state_d   = ST_WRITE;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (tmr_last) begin
          if (op_q == OP_LOCK) lock_set = 1'b1;
          else                 write_en = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_DATA;
      addr_q   <= '0;
      data_q   <= '0;
      need_w_q <= 1'b0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      need_w_q <= need_w_d;
      done_q   <= done_d;
      rej_q    <= rej_d;
    end
  end

  assign busy      = tmr_run;
  assign done      = done_q;
  assign rejected  = rej_q;
  assign rd_locked = rd_in_range && rd_lock_raw;
endmodule

// File: rtl/eeprom_update_ctrl_chk.sv
module eeprom_update_ctrl_chk #(
  parameter int LOCK_N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_req,
  input logic              lock_req,
  input logic              busy,
  input logic              done,
  input logic              rejected,
  input logic [LOCK_N-1:0] lock_vec
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  busy_start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(upd_req || lock_req));

  // R8
  reject_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> done);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_vec) & ~lock_vec) == '0);
endmodule

bind eeprom_update_ctrl eeprom_update_ctrl_chk #(.LOCK_N(LOCK_N)) u_chk (
  .clk, .rst_n, .upd_req, .lock_req, .busy, .done, .rejected, .lock_vec
);

// File: tb/tb_eeprom_update_ctrl.sv
module tb_eeprom_update_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_req = 1'b0, lock_req = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_locked, busy, done, rejected;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_update_ctrl #(.PHASE_CYCLES(PH)) dut (
    .clk, .rst_n, .upd_req, .lock_req, .addr, .wdata, .rd_addr,
    .rd_data, .rd_locked, .busy, .done, .rejected
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind(1) addr(8) data(8) phases(2) rej(1) expected byte(8)
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 8'h40, 8'hA5, 2'd1, 1'b0, 8'hA5},
    {1'b0, 8'h40, 8'hA5, 2'd0, 1'b0, 8'hA5},
    {1'b0, 8'h40, 8'h5A, 2'd2, 1'b0, 8'h5A},
    {1'b0, 8'h40, 8'hFF, 2'd1, 1'b0, 8'hFF},
    {1'b0, 8'h05, 8'h0F, 2'd1, 1'b0, 8'h0F},
    {1'b1, 8'h05, 8'h00, 2'd1, 1'b0, 8'h0F},
    {1'b0, 8'h05, 8'hF0, 2'd0, 1'b1, 8'h0F},
    {1'b1, 8'h05, 8'h00, 2'd0, 1'b0, 8'h0F},
    {1'b1, 8'h20, 8'h00, 2'd0, 1'b1, 8'hFF},
    {1'b0, 8'h1F, 8'h00, 2'd1, 1'b0, 8'h00},
    {1'b0, 8'hFF, 8'h80, 2'd1, 1'b0, 8'h80},
    {1'b0, 8'h20, 8'h33, 2'd1, 1'b0, 8'h33}
  };

  task automatic run_op(input logic kind, input logic [7:0] a, input logic [7:0] d,
                        output int lat, output logic rej, output logic saw_busy);
    @(negedge clk);
    addr = a; wdata = d;
    upd_req = !kind; lock_req = kind;
    @(negedge clk);
    upd_req = 1'b0; lock_req = 1'b0;
    lat = 1; saw_busy = 1'b0;
    while (!done && lat < 1000) begin
      saw_busy |= busy;
      @(negedge clk);
      lat++;
    end
    rej = rejected;
  endtask

  function automatic logic [7:0] rd(input logic [7:0] a);
    return 8'h00;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int  lat;
    logic rej, sb;
    bit  all_ff, no_lock;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done at reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    all_ff = 1; no_lock = 1;
    for (int i = 0; i < 256; i++) begin
      rd_addr = 8'(i); #1;
      if (rd_data != 8'hFF) all_ff = 0;
      if (rd_locked) no_lock = 0;
    end
    chk(all_ff, "R1 all bytes 0xFF", all_ff, 1);
    chk(no_lock, "R1 no protection bits", no_lock, 1);

    // Table walk: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic kind; logic [7:0] a, d, exp_b; logic [1:0] ph; logic er;
      {kind, a, d, ph, er, exp_b} = VEC[v];
      run_op(kind, a, d, lat, rej, sb);
      chk(lat == 1 + int'(ph) * PH, $sformatf("R3/R4/R7 latency vec %0d", v), lat, 1 + int'(ph) * PH);
      chk(rej == er, $sformatf("R8/R9 rejected vec %0d", v), rej, er);
      rd_addr = a; #1;
      chk(rd_data == exp_b, $sformatf("R2 byte vec %0d", v), rd_data, exp_b);
      if (ph == 0) chk(!sb, $sformatf("R5 no busy vec %0d", v), sb, 0);
      @(negedge clk);
      chk(!done, $sformatf("R7 single pulse vec %0d", v), done, 0);
    end

    // R9 lock bits
    rd_addr = 8'h05; #1;
    chk(rd_locked == 1, "R9 byte 5 locked", rd_locked, 1);
    rd_addr = 8'h20; #1;
    chk(rd_locked == 0, "R9 byte 32 not lockable", rd_locked, 0);

    // R6 request during busy is ignored
    @(negedge clk);
    addr = 8'h60; wdata = 8'h00; upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    chk(busy == 1, "R6 busy during phase", busy, 1);
    addr = 8'h61; wdata = 8'h00; upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; lock_req = 1'b0;
    lat = 2;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    chk(lat == 1 + PH, "R6 latency unaffected", lat, 1 + PH);
    @(negedge clk);
    chk(!done && !busy, "R6 second request dropped", {done, busy}, 0);
    rd_addr = 8'h61; #1;
    chk(rd_data == 8'hFF, "R6 ignored target unchanged", rd_data, 8'hFF);
    rd_addr = 8'h60; #1;
    chk(rd_data == 8'h00, "R2 first target written", rd_data, 8'h00);

    // R9 update wins over lock in same cycle
    @(negedge clk);
    addr = 8'h03; wdata = 8'h3C; upd_req = 1'b1; lock_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; lock_req = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    rd_addr = 8'h03; #1;
    chk(rd_data == 8'h3C && !rd_locked, "R9 update priority", {rd_data, rd_locked}, 9'h078);

    // R8 locked byte 5 still refuses after other traffic
    run_op(1'b0, 8'h05, 8'hFF, lat, rej, sb);
    rd_addr = 8'h05; #1;
    chk(rej && rd_data == 8'h0F && lat == 1, "R8 locked byte refuses", rd_data, 8'h0F);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule